// File: doc/BRIEF.md
# Daisy-Chain Serial DAC Write Controller

This block sits on the host side of a chain of serial 10-bit digital-to-analog converters. In the chain, each converter's serial output feeds the next one's serial input. On a one-cycle start strobe the controller captures one code per device. It builds a 16-bit word for each device: four filler bits, then the code MSB first, then two trailing zeros. It sends every word of the chain in one chip-select window. The word for the device farthest from the host goes out first, so each converter holds its own word when chip select rises and loads it.

The serial clock idles low, and receivers sample on its rising edge (SPI mode 0). The controller times the clock high phase, the clock low phase, the chip-select setup and the chip-select high gap by counting system clocks. Each count is derived from a minimum time in picoseconds, rounded up. The low phase also covers the output delay of one converter plus the input setup of the next. A one-cycle done pulse marks the end of the gap that follows chip select rising.

The control state machine has five states:
- IDLE leaves for SETUP when start is seen.
- SETUP leaves for HIGH when its count expires.
- HIGH leaves for LOW when its count expires.
- LOW returns to HIGH while bits remain, and goes to GAP after the last bit.
- GAP returns to IDLE and raises done.

Top module: `dacchain_writer`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, sdo is 0 and done is 0.
- R2: Each device word is 16 bits, sent MSB first: bits 15..12 filler (zero), bits 11..2 the device code MSB first, bits 1..0 zero.
- R3: One chip-select window carries exactly 16·N_DEV rising clock edges. The word for device N_DEV−1 is sent first and the word for device 0 last. codes[k*10 +: 10] is device k's code.
- R4: sclk is 0 whenever cs_n is 1. cs_n changes only when sclk is 0 both in the cycle of the change and in the cycle before it.
- R5: sdo is stable from the cycle before each rising sclk edge until sclk falls. During a transfer, sdo changes only in the second low cycle after a falling edge.
- R6: Each sclk high phase lasts HI_CYC system cycles. Each sclk low phase between two rising edges lasts LO_CYC cycles.
- R7: From cs_n falling to the first rising sclk edge takes SU_CYC cycles. From the last falling sclk edge to cs_n rising takes LO_CYC cycles.
- R8: cs_n stays 1 for GAP_CYC cycles before done pulses for exactly one cycle. A start raised in the done cycle is accepted, and cs_n falls on the next cycle.
- R9: A start, or a change of codes, while a transfer is running has no effect on that transfer and starts no further transfer.
- R10: Each count is the minimum time divided by the system clock period, rounded up. LO_CYC uses the larger of the clock low minimum and the device output delay plus data setup, and is never below 2. With the defaults (20 ns clock) HI_CYC=2, LO_CYC=7, SU_CYC=1, GAP_CYC=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start strobe, taken only in IDLE |
| codes | input | N_DEV*CODE_W | Packed codes, device k at [k*CODE_W +: CODE_W] |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data to the first device |
| done | output | 1 | One-cycle pulse at the end of a write |

## Verification
The done pulse and the acceptance of a new start can fall in the same cycle. The bench raises start at the very sample where done is seen. It then judges that cs_n falls on the next cycle, and that the scoreboard pops both frames intact and in order. A second overlap tests the busy state: the bench raises start and changes codes in the middle of a window. The scoreboard must still see only the original words, and cs_n must stay high after done.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_GAP
    } dcw_state_e;

    // Round a minimum time up to whole system clocks, at least one.
    function automatic int cycles_for(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dcw_packer.sv
module dcw_packer #(
    parameter int N_DEV  = 3,
    parameter int CODE_W = 10,
    parameter int FILL_W = 4,
    parameter int PAD_W  = 2
) (
    input  logic [N_DEV*CODE_W-1:0]                 codes,
    output logic [N_DEV*(FILL_W+CODE_W+PAD_W)-1:0]  frame_bits
);
    localparam int WORD_W = FILL_W + CODE_W + PAD_W;

    // Device k occupies word slot k; the highest slot is shifted out first.
    for (genvar k = 0; k < N_DEV; k++) begin : g_word
        assign frame_bits[k*WORD_W +: WORD_W] =
            {{FILL_W{1'b0}}, codes[k*CODE_W +: CODE_W], {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/dcw_phase_timer.sv
module dcw_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             expired
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (count != '0)
            count <= count - 1'b1;
    end

    assign expired = (count == '0);
endmodule

// File: rtl/dcw_shifter.sv
module dcw_shifter #(
    parameter int WIDTH = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift,
    output logic             sdo
);
    logic [WIDTH-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr <= '0;
        else if (load)
            sr <= load_val;
        else if (shift)
            sr <= {sr[WIDTH-2:0], 1'b0};
    end

    assign sdo = sr[WIDTH-1];
endmodule

// File: rtl/dacchain_writer.sv
module dacchain_writer
    import dcw_pkg::*;
#(
    parameter int N_DEV        = 3,
    parameter int CODE_W       = 10,
    parameter int FILL_W       = 4,
    parameter int PAD_W        = 2,
    parameter int SYS_CLK_PS   = 20000,
    parameter int T_SCLK_HI_PS = 35000,
    parameter int T_SCLK_LO_PS = 35000,
    parameter int T_DOUT_PS    = 80000,
    parameter int T_DIN_SU_PS  = 45000,
    parameter int T_CS_SU_PS   = 20000,
    parameter int T_CS_HI_PS   = 20000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [N_DEV*CODE_W-1:0] codes,
    output logic                    cs_n,
    output logic                    sclk,
    output logic                    sdo,
    output logic                    done
);
    localparam int WORD_W   = FILL_W + CODE_W + PAD_W;
    localparam int TOT_BITS = N_DEV * WORD_W;
    localparam int HI_CYC   = cycles_for(T_SCLK_HI_PS, SYS_CLK_PS);
    localparam int LO_RAW   = max2(cycles_for(T_SCLK_LO_PS, SYS_CLK_PS),
                                   cycles_for(T_DOUT_PS + T_DIN_SU_PS, SYS_CLK_PS));
    localparam int LO_CYC   = max2(LO_RAW, 2);
    localparam int SU_CYC   = cycles_for(T_CS_SU_PS, SYS_CLK_PS);
    localparam int GAP_CYC  = cycles_for(T_CS_HI_PS, SYS_CLK_PS);
    localparam int MAX_CYC  = max2(max2(HI_CYC, LO_CYC), max2(SU_CYC, GAP_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);
    localparam int BIT_W    = $clog2(TOT_BITS + 1);

    localparam logic [CNT_W-1:0] HI_LD  = CNT_W'(HI_CYC - 1);
    localparam logic [CNT_W-1:0] LO_LD  = CNT_W'(LO_CYC - 1);
    localparam logic [CNT_W-1:0] SU_LD  = CNT_W'(SU_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LD = CNT_W'(GAP_CYC - 1);
    localparam logic [BIT_W-1:0] TOT_LD = BIT_W'(TOT_BITS);

    dcw_state_e state, nxt;

    logic [TOT_BITS-1:0] frame_bits;
    logic                tmr_load;
    logic [CNT_W-1:0]    tmr_val;
    logic [CNT_W-1:0]    tmr_cnt;
    logic                tmr_exp;
    logic [BIT_W-1:0]    bits_left;
    logic                accept;
    logic                do_shift;

    dcw_packer #(
        .N_DEV (N_DEV),
        .CODE_W(CODE_W),
        .FILL_W(FILL_W),
        .PAD_W (PAD_W)
    ) u_pack (
        .codes     (codes),
        .frame_bits(frame_bits)
    );

    dcw_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .count   (tmr_cnt),
        .expired (tmr_exp)
    );

    assign accept   = (state == ST_IDLE) && start;
    assign do_shift = (state == ST_LOW) && (tmr_cnt == LO_LD) && (bits_left != '0);

    dcw_shifter #(.WIDTH(TOT_BITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .load_val(frame_bits),
        .shift   (do_shift),
        .sdo     (sdo)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // Next state and phase timer reload
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start)   nxt = ST_SETUP;
            ST_SETUP: if (tmr_exp) nxt = ST_HIGH;
            ST_HIGH:  if (tmr_exp) nxt = ST_LOW;
            ST_LOW:   if (tmr_exp) nxt = (bits_left == '0) ? ST_GAP : ST_HIGH;
            ST_GAP:   if (tmr_exp) nxt = ST_IDLE;
            default:               nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        tmr_load = (nxt != state);
        unique case (nxt)
            ST_SETUP: tmr_val = SU_LD;
            ST_HIGH:  tmr_val = HI_LD;
            ST_LOW:   tmr_val = LO_LD;
            ST_GAP:   tmr_val = GAP_LD;
            default:  tmr_val = '0;
        endcase
    end

    // Rising edges still to come in this window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bits_left <= '0;
        else if (accept)
            bits_left <= TOT_LD;
        else if (state == ST_HIGH && tmr_exp)
            bits_left <= bits_left - 1'b1;
    end

    // Registered pin outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n <= 1'b1;
            sclk <= 1'b0;
            done <= 1'b0;
        end else begin
            cs_n <= (nxt == ST_IDLE) || (nxt == ST_GAP);
            sclk <= (nxt == ST_HIGH);
            done <= (state == ST_GAP) && (nxt == ST_IDLE);
        end
    end

    assert_cs_move_clk_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cs_n) |-> (!sclk && !$past(sclk)));

    assert_clk_quiet_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_sdo_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(sdo));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && $past(cs_n)));

    assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start) |=> (bits_left <= $past(bits_left)));

endmodule

// File: tb/dacchain_writer_tb_top.sv
`timescale 1ns/1ps
module dacchain_writer_tb_top;
    localparam int N   = 3;
    localparam int CW  = 10;
    localparam int WW  = 16;
    localparam int TOT = N * WW;
    localparam int CLK_PS = 20000;

    function automatic int up(input int t);
        return (t + CLK_PS - 1) / CLK_PS;
    endfunction
    // R10: expected counts from the minimum times
    localparam int HI_E  = up(35000);
    localparam int LO_E  = (up(35000) > up(125000)) ? up(35000) : up(125000);
    localparam int SU_E  = up(20000);
    localparam int GAP_E = up(20000);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [N*CW-1:0] codes = '0;
    logic cs_n, sclk, sdo, done;

    always #10 clk = ~clk;

    dacchain_writer dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .codes(codes),
        .cs_n(cs_n), .sclk(sclk), .sdo(sdo), .done(done)
    );

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor / scoreboard
    logic p_sclk = 1'b0, p_cs = 1'b1, p_sdo = 1'b0, p_done = 1'b0;
    int lo_cnt = 0, hi_cnt = 0, cslo_cnt = 0, cshi_cnt = 0, nbits = 0;
    logic [TOT-1:0] cap = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_cs && !cs_n) begin
                chk(!sclk && !p_sclk, "R4 cs fall with sclk low", sclk, 0);
                nbits = 0; cap = '0; cslo_cnt = 0;
            end
            if (!cs_n) cslo_cnt++;
            if (!p_sclk && sclk) begin
                if (!cs_n) begin
                    chk(sdo == p_sdo, "R5 sdo stable into rise", sdo, p_sdo);
                    if (nbits == 0)
                        chk(cslo_cnt == SU_E + 1, "R7 cs setup", cslo_cnt - 1, SU_E);
                    else
                        chk(lo_cnt == LO_E, "R6 R10 low width", lo_cnt, LO_E);
                    cap = {cap[TOT-2:0], sdo};
                    nbits++;
                end else
                    chk(1'b0, "R4 sclk rose with cs high", 1, 0);
            end
            if (p_sclk && !sclk)
                chk(hi_cnt == HI_E, "R6 R10 high width", hi_cnt, HI_E);
            if (!cs_n && !p_cs && sdo != p_sdo)
                chk(!sclk && lo_cnt == 1, "R5 sdo change point", lo_cnt, 1);
            if (!p_cs && cs_n) begin
                chk(!sclk && !p_sclk, "R4 cs rise with sclk low", sclk, 0);
                chk(lo_cnt == LO_E, "R7 cs tail", lo_cnt, LO_E);
                chk(nbits == TOT, "R3 bits per window", nbits, TOT);
                for (int k = 0; k < N; k++) begin
                    logic [15:0] got, ex;
                    got = cap[k*WW +: WW];
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R3 unexpected frame", got, 0);
                    end else begin
                        ex = exp_q.pop_front();
                        chk(got == ex, "R2 R3 device word", got, ex);
                        chk(got[15:12] == 4'd0 && got[1:0] == 2'd0, "R2 fill and pad",
                            {got[15:12], got[1:0]}, 0);
                    end
                end
            end
            if (done) begin
                chk(cs_n == 1'b1, "R8 done with cs high", cs_n, 1);
                chk(cshi_cnt == GAP_E, "R8 cs high gap", cshi_cnt, GAP_E);
            end
            if (p_done) chk(!done, "R8 done one cycle", done, 0);
            if (sclk) hi_cnt = p_sclk ? hi_cnt + 1 : 1;
            else      lo_cnt = p_sclk ? 1 : lo_cnt + 1;
            if (cs_n) cshi_cnt = p_cs ? cshi_cnt + 1 : 1;
            p_sclk = sclk; p_cs = cs_n; p_sdo = sdo; p_done = done;
        end
    end

    // Driver: push expected words (device 0 first) and strobe start
    task automatic send(input logic [N*CW-1:0] c);
        codes = c;
        for (int k = 0; k < N; k++)
            exp_q.push_back({4'd0, c[k*CW +: CW], 2'b00});
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R1 reset cs_n", cs_n, 1);
        chk(sclk == 1'b0, "R1 reset sclk", sclk, 0);
        chk(sdo == 1'b0, "R1 reset sdo", sdo, 0);
        chk(done == 1'b0, "R1 reset done", done, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R1 idle after reset", {cs_n, sclk}, 2);

        send({10'h2A5, 10'h000, 10'h3FF});
        wait_done();
        repeat (4) @(negedge clk);

        send({10'h001, 10'h200, 10'h155});
        wait_done();
        // R8: start in the done cycle is accepted
        send({10'h0F0, 10'h30F, 10'h1C3});
        chk(cs_n == 1'b0, "R8 back-to-back start", cs_n, 0);
        wait_done();
        repeat (5) @(negedge clk);

        // R9: start and code change while busy
        send({10'h111, 10'h222, 10'h333});
        repeat (40) @(negedge clk);
        codes = {10'h3FF, 10'h3FF, 10'h3FF};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (20) begin
            @(negedge clk);
            chk(cs_n == 1'b1, "R9 no extra window", cs_n, 1);
        end

        send({10'h3FF, 10'h3FF, 10'h3FF});
        wait_done();
        send({10'h000, 10'h000, 10'h000});
        wait_done();
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all frames seen", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule